// File: doc/BRIEF.md
# Interval Timer Channel

A single down-counting timer channel for a chip's timekeeping. It counts on a one-microsecond tick enable, not on every cycle of the core clock. When its count runs out it raises a level interrupt. Software sets the enable, the mode and a 29-bit count with a single 32-bit write. In periodic mode the channel restarts from the programmed value every time it expires. In one-shot mode it fires once and then goes idle.

A count of N gives an interval of N+1 ticks, so software writes the wanted interval minus one. The interrupt stays high until software writes a clear command. A status register returns the remaining count and whether the channel is running. The tick generator, the bus adapter and the interrupt controller lie outside the block.

Top module: `tick_interval_timer`

## Requirements
- R1: The control word is written at byte offset 0x0. Bit 31 is the enable, bit 30 selects periodic mode (1) or one-shot mode (0), bits 28:0 hold the count N, and bit 29 is ignored. A write with bit 31 set loads N and starts the channel on the next clock edge. The clear register sits at offset 0x4 and the status register at offset 0x8.
- R2: With count N loaded, the interrupt rises at the clock edge that samples the (N+1)th tick, counted from the load. Before that edge it stays low.
- R3: In one-shot mode the channel stops at expiry: status bit 31 reads 0 and no further interrupt occurs, whatever ticks follow.
- R4: In periodic mode the channel reloads N at expiry, and the next expiry comes N+1 ticks later.
- R5: The count and the running state change only on clock cycles where tick_en is high, or when a control write arrives.
- R6: A control write with bit 31 clear (including all zeros) stops the channel on the next edge. The remaining count is kept frozen, and no interrupt arises from it later.
- R7: The interrupt is level-sensitive and active high. It holds for any number of cycles until it is cleared.
- R8: A write to the clear register with bit 30 set drops the interrupt on the next edge. A write to the clear register with bit 30 clear has no effect.
- R9: A control write to a running channel restarts the count from the new value. If a tick falls in the same cycle as the write, the new value is loaded without being decremented.
- R10: If an expiry and a clear write fall in the same cycle, the interrupt stays high.
- R11: A read (bus_sel=1, bus_wr=0) at offset 0x8 returns, in the same cycle, the remaining count in bits 28:0, the running flag in bit 31, and zeros in bits 30:29. Reads at 0x0 and 0x4 return zero.
- R12: The largest count, 0x1FFFFFFF, is accepted and counts down like any other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | One-microsecond count enable, one clock cycle wide |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read request |
| irq | output | 1 | Level interrupt, active high |

## Verification
Two kinds of event can fall in the same cycle: a tick that makes the channel expire together with a clear write, and a tick together with a control write. The bench provokes the first with a periodic count of zero, so every tick expires. It drives the clear write on the very cycle of a tick and expects the interrupt to stay high. It then expects the interrupt to drop after a plain clear. For the second, the bench raises a tick in the same cycle as a new control write. It then expects status to read the new value undecremented.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_CLR  = 4;
  localparam int unsigned OFS_STAT = 8;

  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned PER_BIT = 30;
  localparam int unsigned CLR_BIT = 30;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CLR  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 29
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              active_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              load_o,
  output logic              stop_o,
  output logic              periodic_o,
  output logic [CNT_W-1:0]  value_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int PAD_W = DATA_W - 1 - CNT_W;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(OFS_CTRL))      return SEL_CTRL;
    else if (a == ADDR_W'(OFS_CLR))  return SEL_CLR;
    else if (a == ADDR_W'(OFS_STAT)) return SEL_STAT;
    else                             return SEL_NONE;
  endfunction

  reg_sel_e sel;
  logic     wr_ctrl;
  logic     wr_clr;
  logic     rd_stat;

  always_comb begin
    sel     = decode_sel(bus_addr);
    wr_ctrl = bus_sel && bus_wr && (sel == SEL_CTRL);
    wr_clr  = bus_sel && bus_wr && (sel == SEL_CLR);
    rd_stat = bus_sel && !bus_wr && (sel == SEL_STAT);
  end

  assign load_o     = wr_ctrl && bus_wdata[EN_BIT];
  assign stop_o     = wr_ctrl && !bus_wdata[EN_BIT];
  assign periodic_o = bus_wdata[PER_BIT];
  assign value_o    = bus_wdata[CNT_W-1:0];
  assign clr_o      = wr_clr && bus_wdata[CLR_BIT];

  always_comb begin
    bus_rdata = '0;
    if (rd_stat) bus_rdata = {active_i, {PAD_W{1'b0}}, count_i};
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] value_i,
  output logic [CNT_W-1:0] count_o,
  output logic             active_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             per_q, per_d;
  logic             act_q, act_d;

  function automatic logic is_terminal(input logic [CNT_W-1:0] c);
    return c == '0;
  endfunction

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] r,
                                                  input logic             p);
    if (!is_terminal(c)) return c - CNT_W'(1);
    else if (p)          return r;
    else                 return c;
  endfunction

  assign expire_o = act_q && tick_i && is_terminal(count_q) && !load_i && !stop_i;

  always_comb begin
    count_d  = count_q;
    reload_d = reload_q;
    per_d    = per_q;
    act_d    = act_q;
    if (load_i) begin
      count_d  = value_i;
      reload_d = value_i;
      per_d    = periodic_i;
      act_d    = 1'b1;
    end else if (stop_i) begin
      act_d = 1'b0;
    end else if (act_q && tick_i) begin
      count_d = step_count(count_q, reload_q, per_q);
      if (is_terminal(count_q) && !per_q) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      per_q    <= 1'b0;
      act_q    <= 1'b0;
    end else begin
      count_q  <= count_d;
      reload_q <= reload_d;
      per_q    <= per_d;
      act_q    <= act_d;
    end
  end

  assign count_o  = count_q;
  assign active_o = act_q;

  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && tick_i && !load_i && !stop_i && count_o != '0)
      |=> count_o == $past(count_o) - CNT_W'(1));

  assert_oneshot_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !per_q) |=> !active_o);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && per_q) |=> (active_o && count_o == $past(reload_q)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i && !stop_i) |=> ($stable(count_o) && $stable(active_o)));

  assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!active_o && $stable(count_o)));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (active_o && count_o == $past(value_i)));

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic clr_i,
  output logic irq_o
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (expire_i) irq_q <= 1'b1;
    else if (clr_i)    irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  assert_rise_on_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(expire_i));

  assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_i) |=> irq_o);

  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !expire_i) |=> !irq_o);

  assert_expiry_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> irq_o);

endmodule

// File: rtl/tick_interval_timer.sv
module tick_interval_timer #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic             load_w;
  logic             stop_w;
  logic             periodic_w;
  logic [CNT_W-1:0] value_w;
  logic             clr_w;
  logic [CNT_W-1:0] count_w;
  logic             active_w;
  logic             expire_w;

  tmr_regdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .active_i   (active_w),
    .count_i    (count_w),
    .load_o     (load_w),
    .stop_o     (stop_w),
    .periodic_o (periodic_w),
    .value_o    (value_w),
    .clr_o      (clr_w),
    .bus_rdata  (bus_rdata)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_en),
    .load_i     (load_w),
    .stop_i     (stop_w),
    .periodic_i (periodic_w),
    .value_i    (value_w),
    .count_o    (count_w),
    .active_o   (active_w),
    .expire_o   (expire_w)
  );

  tmr_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (expire_w),
    .clr_i    (clr_w),
    .irq_o    (irq)
  );

  assert_load_stop_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_w && stop_w));

  assert_no_spurious_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_w && !load_w) |=> !$rose(irq));

endmodule

// File: tb/tick_interval_timer_tb_top.sv
module tick_interval_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int unsigned cyc = 0;
  int unsigned exp_q[$];
  logic irq_prev = 1'b0;
  bit done = 1'b0;

  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_CLR  = 4'h4;
  localparam logic [3:0] A_STAT = 4'h8;

  tick_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: each interrupt rise is matched against the expected stamp
  always @(posedge clk) begin
    #1;
    if (rst_n && irq && !irq_prev) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected interrupt rise act=cycle %0d exp=none", cyc);
      end else begin
        int unsigned e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          bad++;
          $display("FAIL R2 interrupt rise act=cycle %0d exp=cycle %0d", cyc, e);
        end
      end
    end
    irq_prev = irq;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cycle_drive(input logic t, input logic s, input logic w,
                             input logic [3:0] a, input logic [31:0] d, input bit fire);
    @(negedge clk);
    tick_en = t; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    if (fire) exp_q.push_back(cyc + 1);
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cycle_drive(1'b0, 1'b1, 1'b1, a, d, 1'b0);
  endtask

  task automatic tick(input bit fire);
    cycle_drive(1'b1, 1'b0, 1'b0, 4'h0, 32'h0, fire);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic check_stat(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(A_STAT, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset irq", {31'b0, irq}, 32'h0);
    check_stat("R11 reset status", 32'h0);

    // R1/R2/R3: one-shot, N=3
    wr(A_CTRL, 32'h8000_0003);
    check_stat("R1 load status", 32'h8000_0003);
    tick(0); tick(0); tick(0);
    check("R2 no irq before N+1", {31'b0, irq}, 32'h0);
    check_stat("R2 count at zero", 32'h8000_0000);
    tick(1);
    check("R2 irq after N+1", {31'b0, irq}, 32'h1);
    check_stat("R3 one-shot stopped", 32'h0000_0000);
    // R7: level holds
    repeat (10) @(negedge clk);
    check("R7 irq held", {31'b0, irq}, 32'h1);
    // R8: bit30 clear has no effect
    wr(A_CLR, 32'hBFFF_FFFF);
    check("R8 clear without bit30", {31'b0, irq}, 32'h1);
    wr(A_CLR, 32'h4000_0000);
    check("R8 clear with bit30", {31'b0, irq}, 32'h0);
    // R3: no further interrupt
    repeat (8) tick(0);
    check("R3 no refire", {31'b0, irq}, 32'h0);

    // R4: periodic, N=2
    wr(A_CTRL, 32'hC000_0002);
    tick(0); tick(0); tick(1);
    check_stat("R4 reloaded", 32'h8000_0002);
    wr(A_CLR, 32'h4000_0000);
    tick(0); tick(0); tick(1);
    check("R4 second expiry", {31'b0, irq}, 32'h1);
    wr(A_CLR, 32'h4000_0000);

    // R5: no tick, no change
    wr(A_CTRL, 32'hC000_0002);
    tick(0);
    repeat (20) @(negedge clk);
    check_stat("R5 stable without tick", 32'h8000_0001);

    // R6: stop with all zeros
    wr(A_CTRL, 32'h0);
    check_stat("R6 stopped frozen", 32'h0000_0001);
    repeat (6) tick(0);
    check("R6 no irq after stop", {31'b0, irq}, 32'h0);

    // R9: restart, and restart together with a tick
    wr(A_CTRL, 32'h8000_000A);
    tick(0); tick(0); tick(0);
    check_stat("R9 counted", 32'h8000_0007);
    wr(A_CTRL, 32'h8000_0014);
    check_stat("R9 restart", 32'h8000_0014);
    cycle_drive(1'b1, 1'b1, 1'b1, A_CTRL, 32'h8000_0004, 1'b0);
    check_stat("R9 write wins over tick", 32'h8000_0004);
    wr(A_CTRL, 32'h0);

    // R10: expiry and clear in the same cycle
    wr(A_CTRL, 32'hC000_0000);
    tick(1);
    check("R10 first expiry", {31'b0, irq}, 32'h1);
    cycle_drive(1'b1, 1'b1, 1'b1, A_CLR, 32'h4000_0000, 1'b0);
    check("R10 expiry beats clear", {31'b0, irq}, 32'h1);
    wr(A_CLR, 32'h4000_0000);
    check("R10 plain clear", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h0);

    // R11: other registers read zero
    rd(A_CTRL, v);
    check("R11 ctrl reads zero", v, 32'h0);
    rd(A_CLR, v);
    check("R11 clear reads zero", v, 32'h0);

    // R12 and R1 bit 29 ignored: maximum count
    wr(A_CTRL, 32'hBFFF_FFFF);
    check_stat("R12 max count", 32'h9FFF_FFFF);
    tick(0);
    check_stat("R12 max count decrement", 32'h9FFF_FFFE);
    wr(A_CTRL, 32'h0);

    repeat (3) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2 missing interrupt rises act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule